// File: doc/BRIEF.md
# Four-Channel DAC Command Decoder

This block is the digital front end of a four-channel digital-to-analog converter. A frame-gated serial port brings in 24-bit command words, most significant bit first. Each accepted word writes one channel's staging buffer. The write holds either a new 14-bit output code or a new power state. The word's load field then decides what happens next. The active registers can stay as they are, only the addressed channel can be loaded, or all four channels can be loaded in the same cycle. Power states are double-buffered in the same way as codes. This lets differently configured channels switch together.

The receiver is a four-state machine with states RX_IDLE, RX_SHIFT, RX_OVER and RX_COMMIT:
- RX_IDLE moves to RX_SHIFT when the frame input goes low.
- RX_SHIFT moves to RX_COMMIT when the frame rises after exactly 24 bits. It returns to RX_IDLE when the frame rises after any other count.
- RX_SHIFT moves to RX_OVER when a 25th bit arrives. RX_OVER returns to RX_IDLE when the frame rises.
- RX_COMMIT lasts one cycle, then returns to RX_IDLE.

During RX_COMMIT the word is decoded. The buffers, the active registers and the per-channel update strobes change at the following clock edge. No bit is taken in the cycle spent in RX_COMMIT.

Top module: `dac_cmd_decoder`

## Requirements
- R1: A word is accepted only when exactly 24 bits, each marked by the bit-enable input, are sampled while the frame input is low, and the frame input then returns high. Bits arrive MSB first. Shorter or longer frames change no buffer, active register or strobe.
- R2: A word whose bits 23:22 differ from the 2-bit address strap input is ignored entirely.
- R3: When bit 16 is 0, the word is a data write. The channel selected by bits 18:17 (binary index 0..3) gets bits 15:2 as its buffered code, and its buffered power state is set to 00 (normal).
- R4: When bit 16 is 1, the word is a power-down write. The selected channel's buffered power state takes bits 15:14 (01 = 1k pull-down, 10 = 100k pull-down, 11 = high impedance). Its buffered code is kept, and bits 13:0 have no effect.
- R5: When the load field (bits 21:20) is 00, only the buffer is written. No active register changes and no strobe fires.
- R6: When the load field is 01, the selected channel's active register takes the value just written to its buffer. The other channels stay unchanged.
- R7: When load bit 21 is 1 (load field 10 or 11), the buffer write completes and then all four active registers take their buffer contents at the same edge.
- R8: Each channel whose active register is loaded raises its update strobe for exactly one cycle. The strobe appears in the same cycle the new active value appears, two clock edges after the frame input is sampled high.
- R9: After reset, all buffers and active registers hold code 0 with power state 00, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap_i | input | 2 | Device address compared with word bits 23:22 |
| frm_n_i | input | 1 | Frame gate, active low |
| bit_en_i | input | 1 | Marks a clock cycle that carries a serial bit |
| bit_i | input | 1 | Serial data bit |
| code_o | output | N_CH*14 | Active codes, channel k in bits k*14+13 : k*14 |
| pwr_o | output | N_CH*2 | Active power states, channel k in bits k*2+1 : k*2 |
| upd_o | output | N_CH | One-cycle per-channel load strobes |

## Verification
The bench uses the default four channels and 24-bit words. This keeps the whole command space small enough to sweep. It covers every strap value, every channel, every load code, and a data write plus all three power-down modes, each followed by a word carrying a non-matching address. Because there are only four channels, the bench can compare all active codes, power states and strobes after every word. That exposes any stray load on a channel that was not addressed. Frames of 23 and 25 bits, and a mixed-mode simultaneous power-down, cover the remaining boundary cases.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
    localparam int WORD_W  = 24;
    localparam int CODE_W  = 14;
    localparam int PWR_W   = 2;
    // field positions inside the command word
    localparam int ADDR_HI = 23;
    localparam int ADDR_LO = 22;
    localparam int LD_HI   = 21;
    localparam int LD_LO   = 20;
    localparam int SEL_HI  = 18;
    localparam int SEL_LO  = 17;
    localparam int PD_BIT  = 16;
    localparam int MODE_HI = 15;
    localparam int MODE_LO = 14;
    localparam int CODE_HI = 15;
    localparam int CODE_LO = CODE_HI - CODE_W + 1;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_OVER,
        RX_COMMIT
    } rx_state_e;
endpackage

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
    import dac_cmd_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frm_n,
    input  logic         bit_en,
    input  logic         bit_in,
    output logic         word_vld,
    output logic [W-1:0] word
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

    rx_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     sh_q;
    logic             take;

    assign take = bit_en && !frm_n && (st_q == RX_IDLE || st_q == RX_SHIFT);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:   if (!frm_n) st_d = RX_SHIFT;
            RX_SHIFT: begin
                if (frm_n)                     st_d = (cnt_q == FULL) ? RX_COMMIT : RX_IDLE;
                else if (take && cnt_q == FULL) st_d = RX_OVER;
            end
            RX_OVER:   if (frm_n) st_d = RX_IDLE;
            RX_COMMIT: st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == RX_IDLE)              cnt_q <= take ? CNT_W'(1) : '0;
            else if (take && cnt_q != FULL)   cnt_q <= cnt_q + 1'b1;
            if (take) sh_q <= {sh_q[W-2:0], bit_in};
        end
    end

    always_comb begin
        word_vld = (st_q == RX_COMMIT);
        word     = sh_q;
    end

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> ($past(st_q) == RX_SHIFT && $past(cnt_q) == FULL && $past(frm_n))); // R1
    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R1
endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot
    import dac_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_code,
    input  logic              wr_pwr,
    input  logic [CODE_W-1:0] new_code,
    input  logic [PWR_W-1:0]  new_pwr,
    input  logic              load,
    output logic [CODE_W-1:0] act_code,
    output logic [PWR_W-1:0]  act_pwr,
    output logic              upd
);
    logic [CODE_W-1:0] buf_code_q, buf_code_d;
    logic [PWR_W-1:0]  buf_pwr_q,  buf_pwr_d;

    always_comb begin
        buf_code_d = wr_code ? new_code : buf_code_q;
        buf_pwr_d  = wr_pwr  ? new_pwr  : buf_pwr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_code_q <= '0;
            buf_pwr_q  <= '0;
            act_code   <= '0;
            act_pwr    <= '0;
            upd        <= 1'b0;
        end else begin
            buf_code_q <= buf_code_d;
            buf_pwr_q  <= buf_pwr_d;
            upd        <= load;
            if (load) begin
                act_code <= buf_code_d;
                act_pwr  <= buf_pwr_d;
            end
        end
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> ($stable(act_code) && $stable(act_pwr))); // R8
    AST_STROBE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !load) |=> !upd); // R8
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
    import dac_cmd_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              addr_strap_i,
    input  logic                    frm_n_i,
    input  logic                    bit_en_i,
    input  logic                    bit_i,
    output logic [N_CH*CODE_W-1:0]  code_o,
    output logic [N_CH*PWR_W-1:0]   pwr_o,
    output logic [N_CH-1:0]         upd_o
);
    localparam int SEL_W = $clog2(N_CH);

    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic              commit, is_pd;
    logic [1:0]        ld;
    logic [SEL_W-1:0]  sel;
    logic [CODE_W-1:0] w_code;
    logic [PWR_W-1:0]  w_mode;

    dac_frame_rx #(.W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_n    (frm_n_i),
        .bit_en   (bit_en_i),
        .bit_in   (bit_i),
        .word_vld (word_vld),
        .word     (word)
    );

    always_comb begin
        commit = word_vld && (word[ADDR_HI:ADDR_LO] == addr_strap_i);
        ld     = word[LD_HI:LD_LO];
        sel    = word[SEL_HI:SEL_LO];
        is_pd  = word[PD_BIT];
        w_code = word[CODE_HI:CODE_LO];
        w_mode = word[MODE_HI:MODE_LO];
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic hit;
        assign hit = commit && (sel == SEL_W'(g));
        dac_chan_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_code  (hit && !is_pd),
            .wr_pwr   (hit),
            .new_code (w_code),
            .new_pwr  (is_pd ? w_mode : '0),
            .load     (commit && (ld[1] || (ld[0] && sel == SEL_W'(g)))),
            .act_code (code_o[g*CODE_W +: CODE_W]),
            .act_pwr  (pwr_o[g*PWR_W +: PWR_W]),
            .upd      (upd_o[g])
        );
    end

    AST_ADDR_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word[ADDR_HI:ADDR_LO] != addr_strap_i) |=> (upd_o == '0)); // R2
    AST_BUF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ld == 2'b00) |=> (upd_o == '0)); // R5
    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ld == 2'b01) |=> ($countones(upd_o) == 1)); // R6
    AST_ALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && ld[1]) |=> (upd_o == '1)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> (upd_o == '0)); // R1
endmodule

// File: tb/tb_dac_cmd_decoder.sv
module tb_dac_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap = 2'b00;
    logic        frm_n = 1'b1;
    logic        ben = 1'b0;
    logic        bdat = 1'b0;
    logic [55:0] code_o;
    logic [7:0]  pwr_o;
    logic [3:0]  upd_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [13:0] mb_c [4];
    logic [1:0]  mb_p [4];
    logic [13:0] ma_c [4];
    logic [1:0]  ma_p [4];
    logic [3:0]  m_upd;

    always #2 clk = ~clk;

    dac_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr_strap_i(strap), .frm_n_i(frm_n),
        .bit_en_i(ben), .bit_i(bdat), .code_o(code_o), .pwr_o(pwr_o), .upd_o(upd_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [55:0] exp_code();
        logic [55:0] v;
        for (int k = 0; k < 4; k++) v[k*14 +: 14] = ma_c[k];
        return v;
    endfunction

    function automatic logic [7:0] exp_pwr();
        logic [7:0] v;
        for (int k = 0; k < 4; k++) v[k*2 +: 2] = ma_p[k];
        return v;
    endfunction

    function automatic logic [23:0] mk(input logic [1:0] a, input logic [1:0] ld,
                                       input logic [1:0] ch, input logic pd, input logic [15:0] lo);
        return {a, ld, 1'b0, ch, pd, lo};
    endfunction

    // model from the requirements: R2..R7
    task automatic model(input logic [23:0] w);
        int ch;
        m_upd = 4'b0000;
        if (w[23:22] != strap) return;
        ch = int'(w[18:17]);
        if (w[16]) mb_p[ch] = w[15:14];
        else begin mb_c[ch] = w[15:2]; mb_p[ch] = 2'b00; end
        if (w[21]) begin
            for (int k = 0; k < 4; k++) begin ma_c[k] = mb_c[k]; ma_p[k] = mb_p[k]; end
            m_upd = 4'b1111;
        end else if (w[20]) begin
            ma_c[ch] = mb_c[ch]; ma_p[ch] = mb_p[ch];
            m_upd = 4'b0001 << ch;
        end
    endtask

    // shift nbits (MSB first from bit 23; bits past 24 are zero)
    task automatic send(input logic [23:0] w, input int nbits);
        @(negedge clk);
        frm_n = 1'b0;
        for (int k = 0; k < nbits; k++) begin
            ben  = 1'b1;
            bdat = (k < 24) ? w[23-k] : 1'b0;
            @(negedge clk);
        end
        ben = 1'b0; frm_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic word_chk(input logic [23:0] w, input string tag);
        send(w, 24);
        model(w);
        chk({tag, " R8 strobe"}, 64'(upd_o), 64'(m_upd));
        chk({tag, " code"}, 64'(code_o), 64'(exp_code()));
        chk({tag, " pwr"}, 64'(pwr_o), 64'(exp_pwr()));
        @(negedge clk);
        chk("R8 strobe one cycle", 64'(upd_o), 64'd0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [13:0] cv;
        logic [23:0] w;
        for (int k = 0; k < 4; k++) begin mb_c[k] = '0; mb_p[k] = '0; ma_c[k] = '0; ma_p[k] = '0; end
        repeat (3) @(negedge clk);
        chk("R9 reset code", 64'(code_o), 64'd0);
        chk("R9 reset pwr", 64'(pwr_o), 64'd0);
        chk("R9 reset strobe", 64'(upd_o), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: short and long frames are discarded (load-all words)
        send(mk(2'b00, 2'b10, 2'b01, 1'b0, 16'hABCD), 23);
        chk("R1 short frame strobe", 64'(upd_o), 64'd0);
        chk("R1 short frame code", 64'(code_o), 64'(exp_code()));
        send(mk(2'b00, 2'b10, 2'b10, 1'b0, 16'h1234), 25);
        chk("R1 long frame strobe", 64'(upd_o), 64'd0);
        chk("R1 long frame code", 64'(code_o), 64'(exp_code()));
        // buffers must also be untouched: load all with a pd-only word on ch0
        word_chk(mk(2'b00, 2'b10, 2'b00, 1'b1, 16'h4000), "R1 buffers intact");

        // sweep R2 R3 R4 R5 R6 R7
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int ch = 0; ch < 4; ch++)
                for (int ld = 0; ld < 4; ld++)
                    for (int kind = 0; kind < 4; kind++) begin
                        cv = 14'((s * 64 + ch * 16 + ld * 4 + kind) * 37 + 5);
                        if (kind == 0) w = mk(2'(s), 2'(ld), 2'(ch), 1'b0, {cv, 2'b11});
                        else           w = mk(2'(s), 2'(ld), 2'(ch), 1'b1, {2'(kind), cv});
                        word_chk(w, "R3 R4 R5 R6 R7 sweep");
                        word_chk(mk(2'(s) ^ 2'b01, 2'b10, 2'(ch), 1'b0, {~cv, 2'b00}), "R2 addr mismatch");
                    end
        end

        // R7 mixed power-down modes taking effect together
        strap = 2'b11;
        word_chk(mk(2'b11, 2'b00, 2'b00, 1'b1, 16'h4000), "R5 stage A");
        word_chk(mk(2'b11, 2'b00, 2'b01, 1'b1, 16'h4000), "R5 stage B");
        word_chk(mk(2'b11, 2'b00, 2'b10, 1'b1, 16'h8000), "R5 stage C");
        word_chk(mk(2'b11, 2'b10, 2'b11, 1'b1, 16'h8000), "R7 mixed pd all");
        chk("R7 mixed pd pattern", 64'(pwr_o), 64'h000000000000_A5);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule